// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous binary up-counter built from identical 4-bit stages. Each stage registers its count on the rising clock edge, and all of its bits change together. A stage has a level-sensitive active-low clear that takes effect without waiting for the clock. It also has an active-low parallel preset that is sampled on the clock edge.

Counting needs two enables. The counting gate must be high, and so must the carry-in gate. The carry-in gate is also the only input that gates the stage's carry-out. The carry-out is combinational and is high when the carry-in gate is high and the stage holds all ones.

The top level chains a parameterised number of stages. The carry-out of each stage drives the carry-in gate of the stage above it. Clock, clear, preset and the counting gate are shared by every stage. The result is one wide counter in which every stage changes on the same edge, with no glue logic between stages. The carry-out of the last stage is brought out as a terminal-count flag, so another instance can be chained on top.

Top module: `cascade_counter`

## Requirements
- R1: While `clear_n` is low, `count_q` is zero. This takes effect at once, between clock edges, whatever the clock, `load_n` and both enables are doing.
- R2: A rising edge with `load_n` low and `clear_n` high sets `count_q` to `load_val`, whatever `count_en` and `chain_en` are.
- R3: A rising edge with `load_n` high, `count_en` high and `chain_en` high raises the full-width `count_q` by exactly one.
- R4: A rising edge with `load_n` high and either `count_en` or `chain_en` low leaves `count_q` unchanged.
- R5: `term_cnt` is high exactly when `chain_en` is high and `count_q` is all ones. It follows these in the same cycle and does not depend on `count_en`.
- R6: Counting from all ones gives zero, and `term_cnt` falls in that same cycle.
- R7: A stage above the lowest one advances only on an edge where every stage below it holds all ones. This gives a plain binary carry across the 4-bit boundaries, for example 0x0FF goes to 0x100.
- R8: Clear takes priority over preset, preset takes priority over counting, and counting takes priority over holding.
- R9: Starting from a clear, a preset to 12 followed by six counting edges takes the low stage through 13, 14, 15, 0, 1, 2. Dropping an enable after that holds the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all stages |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous preset, active low |
| count_en | input | 1 | Counting gate shared by all stages |
| chain_en | input | 1 | Carry-in gate of the lowest stage |
| load_val | input | NUM_STAGES*4 | Preset value |
| count_q | output | NUM_STAGES*4 | Current count |
| term_cnt | output | 1 | Carry-out of the highest stage |

## Verification
A preset or a count step is due on the first rising edge after the inputs are set up. The bench drives all inputs away from the edges. It updates its behavioural model at each edge and compares `count_q` two nanoseconds later.

`term_cnt` has no register on its path, so it is checked in the same cycle. It is checked both right after an edge and right after the enables are changed in mid-cycle.

The clear is checked one nanosecond after it is asserted in the middle of a cycle, before any edge arrives. It is then held low across an edge that would otherwise preset and count, to confirm that clear wins.

// File: rtl/cascade_counter_pkg.sv
package cascade_counter_pkg;
    parameter int STAGE_W = 4;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_COUNT = 2'd1,
        OP_LOAD  = 2'd2
    } stage_op_t;

    typedef struct packed {
        logic [STAGE_W-1:0] cnt;
    } stage_st_t;
endpackage

// File: rtl/cnt_carry_look.sv
module cnt_carry_look #(
    parameter int W = 4
) (
    input  logic [W-1:0] cnt,
    input  logic         gate_t,
    output logic         carry
);
    // Look-ahead: the carry comes straight from the current state, with no register.
    always_comb begin
        carry = gate_t & (&cnt);
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cascade_counter_pkg::*;
(
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic               gate_p,
    input  logic               gate_t,
    input  logic [STAGE_W-1:0] pre_d,
    output logic [STAGE_W-1:0] cnt,
    output logic               carry
);
    stage_st_t state_d, state_q;
    stage_op_t op;

    always_comb begin
        state_d = state_q;
        if (!load_n)
            op = OP_LOAD;
        else if (gate_p && gate_t)
            op = OP_COUNT;
        else
            op = OP_HOLD;

        unique case (op)
            OP_LOAD:  state_d.cnt = pre_d;
            OP_COUNT: state_d.cnt = state_q.cnt + 1'b1;
            default:  state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign cnt = state_q.cnt;

    cnt_carry_look #(.W(STAGE_W)) carry_i (
        .cnt    (state_q.cnt),
        .gate_t (gate_t),
        .carry  (carry)
    );

    // R2
    stage_load_chk: assert property (@(posedge clk) disable iff (!clear_n)
        !load_n |=> cnt == $past(pre_d));

    // R3
    stage_inc_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && gate_p && gate_t) |=> cnt == $past(cnt) + 1'b1);

    // R4
    stage_hold_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && !(gate_p && gate_t)) |=> $stable(cnt));

    // R6
    stage_wrap_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && gate_p && gate_t && (&cnt)) |=> cnt == '0);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
    import cascade_counter_pkg::*;
#(
    parameter int NUM_STAGES = 3
) (
    input  logic                            clk,
    input  logic                            clear_n,
    input  logic                            load_n,
    input  logic                            count_en,
    input  logic                            chain_en,
    input  logic [NUM_STAGES*STAGE_W-1:0]   load_val,
    output logic [NUM_STAGES*STAGE_W-1:0]   count_q,
    output logic                            term_cnt
);
    localparam int TOTAL_W = NUM_STAGES * STAGE_W;

    logic [NUM_STAGES:0] t_link;

    assign t_link[0] = chain_en;

    for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
        cnt_stage stage_i (
            .clk     (clk),
            .clear_n (clear_n),
            .load_n  (load_n),
            .gate_p  (count_en),
            .gate_t  (t_link[k]),
            .pre_d   (load_val[k*STAGE_W +: STAGE_W]),
            .cnt     (count_q[k*STAGE_W +: STAGE_W]),
            .carry   (t_link[k+1])
        );
    end

    assign term_cnt = t_link[NUM_STAGES];

    // R3 R7
    full_inc_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && count_en && chain_en) |=> count_q == $past(count_q) + 1'b1);

    // R5
    term_cnt_chk: assert property (@(posedge clk) disable iff (!clear_n)
        term_cnt == (chain_en && (count_q == {TOTAL_W{1'b1}})));

    // R6
    full_wrap_chk: assert property (@(posedge clk) disable iff (!clear_n)
        (load_n && count_en && chain_en && (count_q == {TOTAL_W{1'b1}}))
            |=> (count_q == '0) && !term_cnt);
endmodule

// File: tb/cascade_counter_tb_top.sv
module cascade_counter_tb_top;
    localparam int NS = 3;
    localparam int TW = NS * 4;

    logic          clk = 1'b0;
    logic          clear_n, load_n, count_en, chain_en;
    logic [TW-1:0] load_val;
    logic [TW-1:0] count_q;
    logic          term_cnt;

    logic [TW-1:0] model;
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    cascade_counter #(.NUM_STAGES(NS)) dut_i (
        .clk      (clk),
        .clear_n  (clear_n),
        .load_n   (load_n),
        .count_en (count_en),
        .chain_en (chain_en),
        .load_val (load_val),
        .count_q  (count_q),
        .term_cnt (term_cnt)
    );

    task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_term(input string tag);
        chk(tag, {{(TW-1){1'b0}}, term_cnt},
            {{(TW-1){1'b0}}, (chain_en && model == {TW{1'b1}})});
    endtask

    // one clock edge: update the model, then compare
    task automatic tick(input string tag);
        @(posedge clk);
        if (!clear_n)
            model = '0;
        else if (!load_n)
            model = load_val;
        else if (count_en && chain_en)
            model = model + 1'b1;
        #2;
        chk(tag, count_q, model);
        chk_term(tag);
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        clear_n = 1'b0; load_n = 1'b1; count_en = 1'b0; chain_en = 1'b0;
        load_val = '0; model = '0;
        #5;
        chk("R1 reset", count_q, '0);
        tick("R1 reset held");
        @(negedge clk); clear_n = 1'b1;

        // R9: preset to 12 with both enables low (R2: enables ignored)
        load_n = 1'b0; load_val = 12'd12;
        tick("R2 preset ignores enables");
        chk("R9 low stage preset", {8'd0, count_q[3:0]}, 12'd12);
        load_n = 1'b1; count_en = 1'b1; chain_en = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick("R9 count sequence");
            chk("R9 low stage", {8'd0, count_q[3:0]}, TW'((13 + i) % 16));
        end
        count_en = 1'b0;
        tick("R4 hold count_en low");
        tick("R4 hold count_en low");
        chk("R9 inhibit value", count_q, 12'h012);
        count_en = 1'b1; chain_en = 1'b0;
        tick("R4 hold chain_en low");

        // R5 / R6: near the top, with terminal count
        load_n = 1'b0; load_val = 12'hFFD; chain_en = 1'b1;
        tick("R2 preset near max");
        load_n = 1'b1;
        tick("R3 step");
        tick("R3 step to max");
        chk("R5 term high at max", {11'd0, term_cnt}, 12'd1);
        count_en = 1'b0; #1;
        chk("R5 term ignores count_en", {11'd0, term_cnt}, 12'd1);
        chain_en = 1'b0; #1;
        chk("R5 term needs chain_en", {11'd0, term_cnt}, 12'd0);
        tick("R4 hold at max");
        chain_en = 1'b1; count_en = 1'b1; #1;
        chk_term("R5 term follows chain_en");
        tick("R6 wrap to zero");
        chk("R6 term falls on wrap", {11'd0, term_cnt}, 12'd0);
        chk("R6 wrapped", count_q, 12'h000);

        // R7: stage boundaries
        load_n = 1'b0; load_val = 12'h0FE;
        tick("R7 preset");
        load_n = 1'b1;
        tick("R7 low stage at max");
        tick("R7 cross two boundaries");
        chk("R7 0x100", count_q, 12'h100);
        load_n = 1'b0; load_val = 12'h00F;
        tick("R7 preset");
        load_n = 1'b1;
        tick("R7 cross one boundary");
        chk("R7 0x010", count_q, 12'h010);

        // R8: preset during active counting
        load_n = 1'b0; load_val = 12'h5A5;
        tick("R8 preset beats count");
        chk("R8 preset value", count_q, 12'h5A5);
        load_n = 1'b1;
        tick("R3 after preset");

        // R1 / R8: clear between edges, held across an edge that would preset
        @(negedge clk);
        clear_n = 1'b0; #1;
        model = '0;
        chk("R1 async clear mid-cycle", count_q, '0);
        load_n = 1'b0; load_val = 12'h777;
        tick("R8 clear beats preset");
        @(negedge clk); clear_n = 1'b1; load_n = 1'b1;
        tick("R3 count after clear");

        // mixed patterns
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            load_n   = ~(lfsr[2:0] == 3'b000);
            count_en = lfsr[3] | lfsr[4];
            chain_en = lfsr[5] | lfsr[6] | lfsr[7];
            load_val = (lfsr[8]) ? 12'hFFE : {lfsr[11:0]};
            tick("R3 R4 mixed");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule